// File: doc/BRIEF.md
# Ones' Complement Prefix Adder

This block adds two unsigned `WIDTH`-bit operands modulo 2^WIDTH − 1, which is ones' complement addition. The carry that leaves the top bit is not dropped. It re-enters at bit 0. No wire runs from carry out back to carry in, so the circuit has no combinational loop. A Kogge-Stone prefix tree produces the group generate and group propagate signals over every low-order span. One further prefix level then merges the wrapped carry into each bit's incoming carry. The block is purely combinational and holds no state.

The `one_zero` input selects how zero is represented. With `one_zero` low, the block gives the classic ones' complement result, where the all-ones word is a second form of zero. With `one_zero` high, every result congruent to zero comes out as all zeros, so each residue has exactly one code. Alongside the sum, `eac_flag` reports whether the wrapped carry was applied.

The block has no stream handshake. It is a single combinational operator that the surrounding datapath registers as it sees fit.

Top module: `eac_adder`

## Requirements
- R1: In both modes, `sum` is congruent to `op_a + op_b` modulo 2^WIDTH − 1.
- R2: With `one_zero` = 0, `sum` equals the low WIDTH bits of `op_a + op_b` plus the carry out of that addition. Two operands that are bitwise complements of each other give the all-ones word.
- R3: With `one_zero` = 1, `sum` is never the all-ones word. Every result congruent to zero is all zeros, including the case where both operands are all ones.
- R4: `eac_flag` is 1 exactly when the carry out of `op_a + op_b` is 1. With `one_zero` = 1, it is also 1 when `op_a + op_b` equals 2^WIDTH − 1.
- R5: Two zero operands give `sum` = 0 and `eac_flag` = 0 in both modes.
- R6: The block is correct for any `WIDTH` of 2 or more, including widths that are not a power of two. The bench checks widths 4 and 5 exhaustively, and checks 16 with random operands.
- R7: The outputs depend only on the present inputs. They are valid within the same time step as an input change and have no dependence on earlier inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand |
| one_zero | input | 1 | 1: zero has a single form (all zeros); 0: all ones is also zero |
| sum | output | WIDTH | Sum modulo 2^WIDTH − 1 |
| eac_flag | output | 1 | Wrapped carry added at bit 0 |

## Verification
The bench targets the cases where a wrapped-carry adder most often goes wrong:

- **Complementary operands.** A design that takes the single-zero carry condition in both modes would turn the all-ones result into zero in the two-zero mode.
- **Both operands all ones.** In single-zero mode, a design that only checks group propagate would leave all ones on the output instead of zero.
- **Sums just past the top.** A design that drops the wrapped carry, or feeds it only into the low bits that are resolved in log2(WIDTH) levels, returns a result one too small or corrupts the upper bits.
- **An odd width.** Exhaustive sweeps at width 5 expose a prefix tree that only works for powers of two.

// File: rtl/eac_pkg.sv
package eac_pkg;

  typedef struct packed {
    logic g;
    logic p;
  } pg_t;

  // combine a high-order span with the adjacent low-order span
  function automatic pg_t pg_merge(input pg_t hi, input pg_t lo);
    pg_t r;
    r.g = hi.g | (hi.p & lo.g);
    r.p = hi.p & lo.p;
    return r;
  endfunction

endpackage

// File: rtl/eac_pg_bits.sv
module eac_pg_bits
  import eac_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  output pg_t  [WIDTH-1:0] pg_bit
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign pg_bit[i].g = op_a[i] & op_b[i];
    assign pg_bit[i].p = op_a[i] ^ op_b[i];
  end

endmodule

// File: rtl/eac_prefix_tree.sv
module eac_prefix_tree
  import eac_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  pg_t [WIDTH-1:0] pg_bit,
  output pg_t [WIDTH-1:0] pg_span
);

  localparam int LEVELS = (WIDTH > 1) ? $clog2(WIDTH) : 1;

  pg_t [WIDTH-1:0] stage [0:LEVELS];

  assign stage[0] = pg_bit;

  for (genvar k = 0; k < LEVELS; k++) begin : g_lvl
    localparam int DIST = 1 << k;
    for (genvar i = 0; i < WIDTH; i++) begin : g_node
      if (i >= DIST) begin : g_merge
        assign stage[k+1][i] = pg_merge(stage[k][i], stage[k][i-DIST]);
      end else begin : g_pass
        assign stage[k+1][i] = stage[k][i];
      end
    end
  end

  // pg_span[i] covers bits i down to 0
  assign pg_span = stage[LEVELS];

endmodule

// File: rtl/eac_sum_stage.sv
module eac_sum_stage
  import eac_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  pg_t  [WIDTH-1:0] pg_bit,
  input  pg_t  [WIDTH-1:0] pg_span,
  input  logic             one_zero,
  output logic [WIDTH-1:0] sum,
  output logic             eac_flag
);

  logic             wrap;
  logic [WIDTH-1:0] carry;
  logic [WIDTH-1:0] g_vec;
  logic [WIDTH-1:0] p_vec;
  logic             both_full;

  assign wrap = pg_span[WIDTH-1].g | (one_zero & pg_span[WIDTH-1].p);

  // extra prefix level: fold the wrapped carry into every bit
  assign carry[0] = wrap;
  for (genvar i = 1; i < WIDTH; i++) begin : g_carry
    assign carry[i] = pg_span[i-1].g | (pg_span[i-1].p & wrap);
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_vec_split
    assign g_vec[i] = pg_bit[i].g;
    assign p_vec[i] = pg_bit[i].p;
  end

  // all-ones plus all-ones is the only wrapped case that yields all ones
  assign both_full = &g_vec;

  always_comb begin
    if (one_zero && both_full) sum = '0;
    else                       sum = p_vec ^ carry;
  end

  assign eac_flag = wrap;

endmodule

// File: rtl/eac_adder.sv
module eac_adder
  import eac_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             one_zero,
  output logic [WIDTH-1:0] sum,
  output logic             eac_flag
);

  pg_t [WIDTH-1:0] pg_bit;
  pg_t [WIDTH-1:0] pg_span;

  eac_pg_bits #(.WIDTH(WIDTH)) u_pg (
    .op_a   (op_a),
    .op_b   (op_b),
    .pg_bit (pg_bit)
  );

  eac_prefix_tree #(.WIDTH(WIDTH)) u_tree (
    .pg_bit  (pg_bit),
    .pg_span (pg_span)
  );

  eac_sum_stage #(.WIDTH(WIDTH)) u_sum (
    .pg_bit   (pg_bit),
    .pg_span  (pg_span),
    .one_zero (one_zero),
    .sum      (sum),
    .eac_flag (eac_flag)
  );

endmodule

// File: rtl/eac_adder_chk.sv
module eac_adder_chk #(
  parameter int WIDTH = 16
) (
  input logic [WIDTH-1:0] op_a,
  input logic [WIDTH-1:0] op_b,
  input logic             one_zero,
  input logic [WIDTH-1:0] sum,
  input logic             eac_flag
);

  localparam logic [WIDTH:0] MODV = {1'b0, {WIDTH{1'b1}}};

  logic [WIDTH:0] wide;
  logic [WIDTH:0] sum_w;

  always_comb begin
    wide  = {1'b0, op_a} + {1'b0, op_b};
    sum_w = {1'b0, sum};

    // R1: residue matches
    a_r1_congruent: assert ((sum_w % MODV) == (wide % MODV))
      else $error("R1 residue mismatch");

    // R3: single-zero mode never emits all ones
    if (one_zero)
      a_r3_no_all_ones: assert (sum != {WIDTH{1'b1}})
        else $error("R3 all ones in single-zero mode");

    // R4: a carry out always raises the flag
    if (wide[WIDTH])
      a_r4_flag_on_carry: assert (eac_flag)
        else $error("R4 flag missing on carry out");

    // R2: complementary operands give all ones, no wrap
    if (!one_zero && (op_b == ~op_a))
      a_r2_complement: assert (sum == {WIDTH{1'b1}} && !eac_flag)
        else $error("R2 complement case");

    // R5: zero operands
    if (op_a == '0 && op_b == '0)
      a_r5_zero: assert (sum == '0 && !eac_flag)
        else $error("R5 zero case");
  end

endmodule

bind eac_adder eac_adder_chk #(.WIDTH(WIDTH)) u_chk (
  .op_a     (op_a),
  .op_b     (op_b),
  .one_zero (one_zero),
  .sum      (sum),
  .eac_flag (eac_flag)
);

// File: tb/eac_adder_test.sv
module eac_adder_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;

  logic [15:0] a16, b16, s16;
  logic [3:0]  a4, b4, s4;
  logic [4:0]  a5, b5, s5;
  logic        m16, m4, m5, f16, f4, f5;

  eac_adder #(.WIDTH(16)) uut (
    .op_a(a16), .op_b(b16), .one_zero(m16), .sum(s16), .eac_flag(f16));
  eac_adder #(.WIDTH(4)) uut_w4 (
    .op_a(a4), .op_b(b4), .one_zero(m4), .sum(s4), .eac_flag(f4));
  eac_adder #(.WIDTH(5)) uut_w5 (
    .op_a(a5), .op_b(b5), .one_zero(m5), .sum(s5), .eac_flag(f5));

  // reference model from the requirements
  function automatic void model(input longint a, input longint b, input int w,
                                input bit single, output longint s, output bit f);
    longint t, m, co;
    t  = a + b;
    m  = (longint'(1) << w) - 1;
    co = t >> w;
    if (single) begin
      f = (t >= m);
      s = t % m;
    end else begin
      f = (co != 0);
      s = (t & m) + co;
    end
  endfunction

  task automatic check(input string req, input int w, input longint a, input longint b,
                       input bit single, input longint got_s, input bit got_f);
    longint es;
    bit ef;
    model(a, b, w, single, es, ef);
    n_checks++;
    if (got_s != es || got_f != ef) begin
      n_errors++;
      $display("FAIL %s w=%0d a=%0h b=%0h mode=%0d: sum=%0h flag=%0d expected sum=%0h flag=%0d",
               req, w, a, b, single, got_s, got_f, es, ef);
    end
  endtask

  task automatic drive16(input logic [15:0] a, input logic [15:0] b, input bit md,
                         input string req);
    @(negedge clk);
    a16 = a; b16 = b; m16 = md;
    #1;  // R7: result valid in the same step, no clock needed
    check(req, 16, a, b, md, s16, f16);
  endtask

  task automatic t_reset_state();
    // R5: zero operands in both modes
    @(negedge clk);
    check("R5", 16, 0, 0, m16, s16, f16);
    drive16(16'h0000, 16'h0000, 1'b1, "R5");
    drive16(16'h0000, 16'h0000, 1'b0, "R5");
  endtask

  task automatic t_complement();
    // R2: a + ~a gives all ones in two-zero mode; R3: zero in single-zero mode
    drive16(16'h1234, 16'hEDCB, 1'b0, "R2");
    drive16(16'h0000, 16'hFFFF, 1'b0, "R2");
    drive16(16'h1234, 16'hEDCB, 1'b1, "R3");
    drive16(16'hA5A5, 16'h5A5A, 1'b1, "R3");
  endtask

  task automatic t_all_ones();
    // R2 and R3: both operands all ones
    drive16(16'hFFFF, 16'hFFFF, 1'b0, "R2");
    drive16(16'hFFFF, 16'hFFFF, 1'b1, "R3");
  endtask

  task automatic t_wrap_edges();
    // R4: carry out just past the top and full-length carry chains
    drive16(16'h8000, 16'h8000, 1'b0, "R4");
    drive16(16'hFFFF, 16'h0001, 1'b0, "R4");
    drive16(16'hFFFF, 16'h0001, 1'b1, "R4");
    drive16(16'h7FFF, 16'h8001, 1'b1, "R4");
    drive16(16'h0001, 16'h0001, 1'b0, "R1");
  endtask

  task automatic t_random16();
    // R1 and R7: random operands back to back, both modes
    for (int i = 0; i < 1500; i++)
      drive16(16'($urandom), 16'($urandom), 1'($urandom), "R1");
  endtask

  task automatic t_sweep4();
    // R6: every operand pair at width 4
    for (int md = 0; md < 2; md++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++) begin
          a4 = 4'(a); b4 = 4'(b); m4 = 1'(md);
          #1;
          check("R6", 4, a, b, 1'(md), s4, f4);
        end
  endtask

  task automatic t_sweep5();
    // R6: every operand pair at width 5, not a power of two
    for (int md = 0; md < 2; md++)
      for (int a = 0; a < 32; a++)
        for (int b = 0; b < 32; b++) begin
          a5 = 5'(a); b5 = 5'(b); m5 = 1'(md);
          #1;
          check("R6", 5, a, b, 1'(md), s5, f5);
        end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  endtask

  initial begin
    a16 = '0; b16 = '0; m16 = 1'b0;
    a4 = '0; b4 = '0; m4 = 1'b0;
    a5 = '0; b5 = '0; m5 = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_complement();
    t_all_ones();
    t_wrap_edges();
    t_random16();
    t_sweep4();
    t_sweep5();
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: run did not complete, actual=timeout expected=done");
    finish_run();
  end

endmodule